// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two direction predictors and, for each branch, picks which one to trust. The address-based predictor keeps a table of 2-bit saturating counters selected by low program-counter bits. The history-based predictor keeps a shift register of recent branch outcomes and uses it to select from a second table of 2-bit counters. A third table of 2-bit counters is selected by the same address bits as the address-based predictor. It records which of the two predictors has been right lately.

A fetch stage presents a program counter on the lookup port. In the same cycle it receives a direction and a flag naming the predictor that produced it. When the branch resolves, the pipeline presents its address and real outcome with a valid strobe. The block then trains both predictors and the selector, and appends the outcome to the history. No tags are kept, so branches whose index bits match share entries.

Top module: `tourney_predictor`

## Requirements
- R1: After reset every counter in both predictor tables holds 1 (weakly not taken), every selector counter holds 1, and the history register is zero. A lookup of any address therefore returns not taken with the selector flag at 0.
- R2: A predictor counter predicts taken when its value is 2 or 3. On each valid resolve it steps up by one for a taken outcome and down by one for a not-taken outcome, saturating at 3 and at 0.
- R3: The history-based table is indexed by the HIST_W-bit history register. A resolve trains the entry selected by the history value from before that resolve. The outcome (1 = taken) is then shifted into bit 0 and the oldest bit is dropped.
- R4: The selector flag is 1 when the selector counter for the looked-up address is 2 or 3. In that case the output direction is the history-based prediction. With a counter of 0 or 1 the flag is 0 and the output is the address-based prediction.
- R5: A selector counter changes only on a resolve where the two predictors disagree. It steps up by one when the history-based one matched the outcome and down by one when the address-based one did. It saturates at 0 and 3.
- R6: A selector saturated on one side needs two consecutive resolves in which the other predictor wins before its preference flips.
- R7: While the resolve valid input is low, no table or history state changes, whatever the other resolve inputs carry.
- R8: Address index bits are pc[PC_LSB+IDX_W-1:PC_LSB] (bits 5:2 by default). Addresses that agree in those bits share the same address-based and selector entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| lkPc | input | PC_W | Address of the branch being looked up |
| lkTaken | output | 1 | Predicted direction, 1 = taken |
| lkUseGlobal | output | 1 | 1 when the history-based predictor supplied lkTaken |
| rsValid | input | 1 | Strobe marking a resolved branch |
| rsPc | input | PC_W | Address of the resolved branch |
| rsTaken | input | 1 | Real outcome of the resolved branch, 1 = taken |

## Verification
Lookup is combinational, so lkTaken and lkUseGlobal follow lkPc within the same cycle. A resolve presented before a rising edge becomes visible on the lookup outputs immediately after that edge. The bench therefore changes inputs on the falling edge, lets one rising edge pass per resolve, and samples the lookup outputs one time unit after setting lkPc at the next falling edge. Expected values come from a behavioural score model that is updated at the moment each resolve is driven.

// File: rtl/tourney_pkg.sv
package tourney_pkg;
  typedef logic [1:0] ctr_t;

  typedef struct packed {
    logic locInc;
    logic locDec;
    logic gloInc;
    logic gloDec;
    logic chsInc;
    logic chsDec;
    logic histShift;
  } updStrobes_t;

  function automatic ctr_t satStep(ctr_t val, logic inc, logic dec);
    ctr_t res;
    res = val;
    if (inc && val != 2'd3) res = val + 2'd1;
    else if (dec && val != 2'd0) res = val - 2'd1;
    return res;
  endfunction
endpackage

// File: rtl/tourney_ctrl.sv
module tourney_ctrl
  import tourney_pkg::*;
(
  input  logic        rsValid,
  input  logic        rsTaken,
  input  logic        rsLocPred,
  input  logic        rsGloPred,
  output updStrobes_t strobes
);
  logic disagree;
  logic gloWins;

  always_comb begin
    disagree = rsLocPred ^ rsGloPred;
    gloWins  = (rsGloPred == rsTaken);
    strobes = '0;
    if (rsValid) begin
      strobes.locInc    = rsTaken;
      strobes.locDec    = !rsTaken;
      strobes.gloInc    = rsTaken;
      strobes.gloDec    = !rsTaken;
      strobes.chsInc    = disagree && gloWins;
      strobes.chsDec    = disagree && !gloWins;
      strobes.histShift = 1'b1;
    end
  end
endmodule

// File: rtl/tourney_datapath.sv
module tourney_datapath
  import tourney_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   lkPc,
  input  logic [PC_W-1:0]   rsPc,
  input  logic              rsTaken,
  input  updStrobes_t       strobes,
  output logic              lkTaken,
  output logic              lkUseGlobal,
  output logic              rsLocPred,
  output logic              rsGloPred,
  output logic [HIST_W-1:0] histQ
);
  localparam int LOC_N = 1 << IDX_W;
  localparam int GLO_N = 1 << HIST_W;

  ctr_t locTab [LOC_N];
  ctr_t chsTab [LOC_N];
  ctr_t gloTab [GLO_N];

  logic [IDX_W-1:0] lkIdx;
  logic [IDX_W-1:0] rsIdx;
  logic             lkLocPred;
  logic             lkGloPred;

  assign lkIdx = lkPc[PC_LSB +: IDX_W];
  assign rsIdx = rsPc[PC_LSB +: IDX_W];

  // lookup side
  always_comb begin
    lkLocPred   = locTab[lkIdx][1];
    lkGloPred   = gloTab[histQ][1];
    lkUseGlobal = chsTab[lkIdx][1];
    lkTaken     = lkUseGlobal ? lkGloPred : lkLocPred;
  end

  // resolve side reads use the pre-update history
  always_comb begin
    rsLocPred = locTab[rsIdx][1];
    rsGloPred = gloTab[histQ][1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LOC_N; i++) begin
        locTab[i] <= 2'd1;
        chsTab[i] <= 2'd1;
      end
      for (int j = 0; j < GLO_N; j++) gloTab[j] <= 2'd1;
      histQ <= '0;
    end else begin
      locTab[rsIdx] <= satStep(locTab[rsIdx], strobes.locInc, strobes.locDec);
      chsTab[rsIdx] <= satStep(chsTab[rsIdx], strobes.chsInc, strobes.chsDec);
      gloTab[histQ] <= satStep(gloTab[histQ], strobes.gloInc, strobes.gloDec);
      if (strobes.histShift) histQ <= {histQ[HIST_W-2:0], rsTaken};
    end
  end
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
  import tourney_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lkPc,
  output logic            lkTaken,
  output logic            lkUseGlobal,
  input  logic            rsValid,
  input  logic [PC_W-1:0] rsPc,
  input  logic            rsTaken
);
  updStrobes_t       strobes;
  logic              rsLocPred;
  logic              rsGloPred;
  logic [HIST_W-1:0] histQ;

  tourney_ctrl u_ctrl (
    .rsValid  (rsValid),
    .rsTaken  (rsTaken),
    .rsLocPred(rsLocPred),
    .rsGloPred(rsGloPred),
    .strobes  (strobes)
  );

  tourney_datapath #(
    .PC_W  (PC_W),
    .PC_LSB(PC_LSB),
    .IDX_W (IDX_W),
    .HIST_W(HIST_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .lkPc       (lkPc),
    .rsPc       (rsPc),
    .rsTaken    (rsTaken),
    .strobes    (strobes),
    .lkTaken    (lkTaken),
    .lkUseGlobal(lkUseGlobal),
    .rsLocPred  (rsLocPred),
    .rsGloPred  (rsGloPred),
    .histQ      (histQ)
  );
endmodule

// File: rtl/tourney_checker.sv
module tourney_checker
  import tourney_pkg::*;
#(
  parameter int HIST_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              rsValid,
  input logic              rsTaken,
  input logic              rsLocPred,
  input logic              rsGloPred,
  input updStrobes_t       strobes,
  input logic [HIST_W-1:0] histQ
);
  // R1
  hist_reset_chk: assert property (@(posedge clk) $rose(rstN) |-> histQ == '0);

  // R3
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    rsValid |=> histQ == {$past(histQ[HIST_W-2:0]), $past(rsTaken)});

  // R7
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rsValid |=> $stable(histQ));

  // R5
  chooser_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rsValid && rsLocPred == rsGloPred) |-> !(strobes.chsInc || strobes.chsDec));

  // R5
  chooser_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.chsInc, strobes.chsDec}));

  // R2
  train_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rsValid && rsTaken) |-> !(strobes.locDec || strobes.gloDec));
endmodule

bind tourney_predictor tourney_checker #(.HIST_W(HIST_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rsValid  (rsValid),
  .rsTaken  (rsTaken),
  .rsLocPred(rsLocPred),
  .rsGloPred(rsGloPred),
  .strobes  (strobes),
  .histQ    (histQ)
);

// File: tb/tourney_predictor_bench.sv
module tourney_predictor_bench;
  localparam int PC_W = 32;
  localparam int IDX_W = 4;
  localparam int HIST_W = 4;
  localparam int LOC_N = 1 << IDX_W;
  localparam int GLO_N = 1 << HIST_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PC_W-1:0] lkPc = '0;
  logic lkTaken, lkUseGlobal;
  logic rsValid = 1'b0;
  logic [PC_W-1:0] rsPc = '0;
  logic rsTaken = 1'b0;

  int checks = 0;
  int errors = 0;
  int mLoc[LOC_N];
  int mChs[LOC_N];
  int mGlo[GLO_N];
  int mHist;

  always #2.5 clk = ~clk;

  tourney_predictor u_tourney_predictor (
    .clk(clk), .rstN(rstN), .lkPc(lkPc), .lkTaken(lkTaken),
    .lkUseGlobal(lkUseGlobal), .rsValid(rsValid), .rsPc(rsPc), .rsTaken(rsTaken)
  );

  function automatic int idxOf(logic [PC_W-1:0] pc);
    return int'(pc[5:2]);
  endfunction

  function automatic int sat(int v, int up);
    if (up != 0) return (v < 3) ? v + 1 : 3;
    return (v > 0) ? v - 1 : 0;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < LOC_N; i++) begin mLoc[i] = 1; mChs[i] = 1; end
    for (int j = 0; j < GLO_N; j++) mGlo[j] = 1;
    mHist = 0;
  endtask

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic resolve(logic [PC_W-1:0] pc, logic t);
    int i, lp, gp;
    @(negedge clk);
    rsValid = 1'b1; rsPc = pc; rsTaken = t;
    i = idxOf(pc);
    lp = (mLoc[i] >= 2); gp = (mGlo[mHist] >= 2);
    if (lp != gp) mChs[i] = sat(mChs[i], (gp == int'(t)) ? 1 : 0);
    mLoc[i] = sat(mLoc[i], int'(t));
    mGlo[mHist] = sat(mGlo[mHist], int'(t));
    mHist = ((mHist << 1) | int'(t)) & (GLO_N - 1);
    @(negedge clk);
    rsValid = 1'b0;
  endtask

  task automatic lookupCheck(logic [PC_W-1:0] pc, string req);
    int i;
    logic expG, expT;
    lkPc = pc;
    #1;
    i = idxOf(pc);
    expG = (mChs[i] >= 2);
    expT = expG ? (mGlo[mHist] >= 2) : (mLoc[i] >= 2);
    check(req, lkUseGlobal, expG, "selector flag");
    check(req, lkTaken, expT, "direction");
  endtask

  task automatic tReset();
    for (int k = 0; k < LOC_N; k += 5) begin
      lkPc = PC_W'(k * 4);
      #1;
      check("R1", lkTaken, 1'b0, "reset direction");
      check("R1", lkUseGlobal, 1'b0, "reset selector");
    end
  endtask

  task automatic tLocalAlias();
    resolve(32'h100, 1'b1);
    lookupCheck(32'h100, "R2");
    resolve(32'h100, 1'b1);
    resolve(32'h100, 1'b1);
    resolve(32'h100, 1'b1);
    lookupCheck(32'h140, "R8");
    resolve(32'h100, 1'b0);
    lookupCheck(32'h100, "R2");
    lookupCheck(32'h104, "R8");
  endtask

  task automatic tGlobalWins();
    for (int k = 0; k < 16; k++) begin
      resolve(32'h20, k[0] ? 1'b0 : 1'b1);
      lookupCheck(32'h20, "R5");
    end
    lookupCheck(32'h20, "R4");
    check("R4", lkUseGlobal, 1'b1, "alternating branch selects history");
    for (int k = 0; k < 6; k++) begin
      resolve(32'h20, 1'b1);
      lookupCheck(32'h20, "R6");
    end
    lookupCheck(32'h24, "R3");
  endtask

  task automatic tIgnore();
    logic snapT[LOC_N];
    logic snapG[LOC_N];
    for (int k = 0; k < LOC_N; k++) begin
      lkPc = PC_W'(k * 4); #1;
      snapT[k] = lkTaken; snapG[k] = lkUseGlobal;
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rsPc = PC_W'(k * 4); rsTaken = k[0];
    end
    @(negedge clk);
    for (int k = 0; k < LOC_N; k++) begin
      lkPc = PC_W'(k * 4); #1;
      check("R7", lkTaken, snapT[k], "direction after idle resolve");
      check("R7", lkUseGlobal, snapG[k], "selector after idle resolve");
    end
  endtask

  task automatic tMixed();
    logic [15:0] lfsr = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      resolve({26'd0, lfsr[3:0], 2'b00}, (lfsr[3:0] < 4'd11) ? lfsr[5] | lfsr[6] : lfsr[7]);
      lookupCheck({26'd0, lfsr[7:4], 2'b00}, "R5");
      lookupCheck({26'd0, lfsr[3:0], 2'b00}, "R3");
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tLocalAlias();
    tGlobalWins();
    tIgnore();
    tMixed();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule